// File: doc/BRIEF.md
# Edge-Programmed Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable waveforms for a raster display, together with a pixel counter, a line counter, a strobe that tells the pixel fetch logic when to begin a frame, and a vertical-event interrupt. Each axis is set up with four cumulative edge positions, all measured from the first count of the sync pulse: where sync ends, where the active region begins, where it ends, and the total count.

Software derives these edges by summing segment lengths. Sync end is the sync length. Active start adds the back porch to that. Active end adds the visible size. The total adds the front porch. For a 640x480 mode with 96/48/16 horizontal and 2/33/10 vertical segments, the horizontal edges are 96, 144, 784, 800 and the vertical edges are 2, 35, 515, 525.

The generator runs only while its enable input is high and both axes hold a legal edge set. Clearing the enable blanks the outputs and parks both counters at the sync start. Setting it again restarts the raster from the top-left sync corner.

Top module: `edge_timing_gen`

## Requirements
- R1: While reset is high, and after reset until the generator is enabled, both counters read 0, data-enable, the fetch strobe, the interrupt pulse and the interrupt status are 0, and each sync output sits at its inactive level.
- R2: While running, the pixel counter steps once per clock from 0 to h_total-1 and then wraps to 0. The line counter steps only on that wrap and runs from 0 to v_total-1.
- R3: The horizontal sync is in its active phase while the pixel counter is below h_sync_end. The vertical sync is in its active phase while the line counter is below v_sync_end. The active level of each sync equals its polarity input (1 means active high, 0 means active low), and its inactive level is the complement. Data-enable is always active high.
- R4: Data-enable is 1 exactly when the generator runs, the pixel counter lies in [h_act_start, h_act_end) and the line counter lies in [v_act_start, v_act_end).
- R5: The interrupt pulse is 1 for exactly one cycle per frame, in the cycle where the pixel counter is 0 and the line counter equals v_act_end.
- R6: The fetch strobe is 1 for exactly one cycle per frame, in the cycle where the pixel counter is 0 and the line counter equals v_sync_end.
- R7: The interrupt status is set in the cycle after an interrupt pulse and holds until a cycle with irq_clr=1 and no pulse. A pulse in the same cycle as irq_clr wins, so the status stays set.
- R8: A clock edge with sync_en=0 returns both counters to 0 and blanks the outputs: sync inactive, data-enable 0, no strobes. The first edge with sync_en=1 starts running at count (0,0), and each later edge advances the pixel counter by one.
- R9: An axis edge set is legal when 0 < sync_end <= act_start, the active span act_end-act_start lies between MIN_SPAN (16) and MAX_SPAN (2048) inclusive, and act_end < total. While either axis is illegal, the generator behaves as if disabled (R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_en | input | 1 | Timing generator run enable |
| hs_pol | input | 1 | Horizontal sync active level |
| vs_pol | input | 1 | Vertical sync active level |
| h_sync_end | input | 12 | Pixel count where horizontal sync ends |
| h_act_start | input | 12 | Pixel count where the active region starts |
| h_act_end | input | 12 | Pixel count where the active region ends |
| h_total | input | 12 | Pixels per line |
| v_sync_end | input | 12 | Line count where vertical sync ends |
| v_act_start | input | 12 | Line count where active lines start |
| v_act_end | input | 12 | Line count where active lines end |
| v_total | input | 12 | Lines per frame |
| irq_clr | input | 1 | Write-one clear of the interrupt status |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display data enable |
| h_count | output | 12 | Current pixel count |
| v_count | output | 12 | Current line count |
| fetch_stb | output | 1 | Frame fetch start strobe |
| vevent_pulse | output | 1 | Single-cycle vertical event interrupt |
| vevent_status | output | 1 | Sticky vertical event status |

## Verification
The bench targets the exclusive upper edges. A design that compared with `<=` at act_end or sync_end would stretch data-enable or sync by one pixel or one line, and the per-cycle scoreboard sees that extra cycle. It also probes the span limits at 15, 16, 2048 and 2049 and a total equal to act_end. A design that accepts an illegal set would start counting, and one that rejects a legal boundary would stay blank. Other targets are polarity changes while running and while disabled, a mid-frame disable followed by re-enable, and a clear that coincides with an interrupt pulse. These expose an inverted sync level, a counter that resumes instead of restarting, or a status that drops a pending event.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Counter and edge register width shared by every module.
    parameter int CW = 12;

    typedef logic [CW-1:0] cnt_t;

    // Cumulative edges of one axis, all measured from the sync start.
    typedef struct packed {
        cnt_t sync_end;
        cnt_t act_start;
        cnt_t act_end;
        cnt_t total;
    } edges_t;

    // Region flags of one axis for the current count.
    typedef struct packed {
        logic sync;
        logic act;
    } zone_t;

    // An edge set may drive the counters only if it is ordered and its
    // visible span fits the supported range.
    function automatic logic edges_legal(edges_t e, int min_span, int max_span);
        int span;
        span = int'(e.act_end) - int'(e.act_start);
        return (e.sync_end != '0) &&
               (e.sync_end <= e.act_start) &&
               (span >= min_span) &&
               (span <= max_span) &&
               (e.act_end < e.total);
    endfunction

endpackage

// File: rtl/dtg_axis_counter.sv
module dtg_axis_counter
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  cnt_t total,
    output cnt_t cnt,
    output logic last
);

    assign last = (cnt >= total - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    // R2: a step below the final count advances by exactly one
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !last) |=> (cnt == $past(cnt) + 1'b1));

    // R2: a step on the final count wraps to zero
    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && last) |=> (cnt == '0));

endmodule

// File: rtl/dtg_zone_decode.sv
module dtg_zone_decode
    import dtg_pkg::*;
(
    input  cnt_t   cnt,
    input  edges_t edges,
    output zone_t  zone
);

    always_comb begin
        zone.sync = (cnt < edges.sync_end);
        zone.act  = (cnt >= edges.act_start) && (cnt < edges.act_end);
    end

endmodule

// File: rtl/dtg_event_unit.sv
module dtg_event_unit
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  cnt_t h_cnt,
    input  cnt_t v_cnt,
    input  cnt_t v_sync_end,
    input  cnt_t v_act_end,
    input  logic irq_clr,
    output logic fetch_stb,
    output logic vevent_pulse,
    output logic vevent_status
);

    logic line_start;

    assign line_start   = running && (h_cnt == '0);
    assign fetch_stb    = line_start && (v_cnt == v_sync_end);
    assign vevent_pulse = line_start && (v_cnt == v_act_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            vevent_status <= 1'b0;
        end else if (vevent_pulse) begin
            vevent_status <= 1'b1;
        end else if (irq_clr) begin
            vevent_status <= 1'b0;
        end
    end

    // R5: the interrupt never lasts two cycles
    assert_pulse_once_R5: assert property (@(posedge clk) disable iff (rst)
        vevent_pulse |=> !vevent_pulse);

    // R6: the fetch strobe never lasts two cycles
    assert_fetch_once_R6: assert property (@(posedge clk) disable iff (rst)
        fetch_stb |=> !fetch_stb);

    // R7: a pulse always lands in the status, even against a clear
    assert_status_set_R7: assert property (@(posedge clk) disable iff (rst)
        vevent_pulse |=> vevent_status);

    // R7: a clear without a competing pulse empties the status
    assert_status_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !vevent_pulse) |=> !vevent_status);

endmodule

// File: rtl/edge_timing_gen.sv
module edge_timing_gen
    import dtg_pkg::*;
#(
    parameter int MIN_SPAN = 16,
    parameter int MAX_SPAN = 2048
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_en,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic [CW-1:0] h_sync_end,
    input  logic [CW-1:0] h_act_start,
    input  logic [CW-1:0] h_act_end,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_sync_end,
    input  logic [CW-1:0] v_act_start,
    input  logic [CW-1:0] v_act_end,
    input  logic [CW-1:0] v_total,
    input  logic          irq_clr,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] h_count,
    output logic [CW-1:0] v_count,
    output logic          fetch_stb,
    output logic          vevent_pulse,
    output logic          vevent_status
);

    localparam int NAX = 2;
    localparam int AX_H = 0;
    localparam int AX_V = 1;

    edges_t           ax_edges [NAX];
    zone_t            zone     [NAX];
    cnt_t             cnt      [NAX];
    logic [NAX-1:0]   ax_ok;
    logic [NAX-1:0]   last;
    logic [NAX-1:0]   step;
    logic             go;
    logic             running;

    assign ax_edges[AX_H] = '{sync_end: h_sync_end, act_start: h_act_start,
                              act_end: h_act_end, total: h_total};
    assign ax_edges[AX_V] = '{sync_end: v_sync_end, act_start: v_act_start,
                              act_end: v_act_end, total: v_total};

    // Lines advance only on the last pixel of a line.
    assign step[AX_H] = running;
    assign step[AX_V] = running & last[AX_H];

    generate
        for (genvar a = 0; a < NAX; a++) begin : g_axis
            assign ax_ok[a] = edges_legal(ax_edges[a], MIN_SPAN, MAX_SPAN);

            dtg_axis_counter u_cnt (
                .clk   (clk),
                .rst   (rst),
                .clear (~go),
                .step  (step[a]),
                .total (ax_edges[a].total),
                .cnt   (cnt[a]),
                .last  (last[a])
            );

            dtg_zone_decode u_dec (
                .cnt   (cnt[a]),
                .edges (ax_edges[a]),
                .zone  (zone[a])
            );
        end
    endgenerate

    assign go = sync_en & (&ax_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
        end else begin
            running <= go;
        end
    end

    assign h_count = cnt[AX_H];
    assign v_count = cnt[AX_V];

    always_comb begin
        hsync = (running && zone[AX_H].sync) ? hs_pol : ~hs_pol;
        vsync = (running && zone[AX_V].sync) ? vs_pol : ~vs_pol;
        de    = running && zone[AX_H].act && zone[AX_V].act;
    end

    dtg_event_unit u_evt (
        .clk           (clk),
        .rst           (rst),
        .running       (running),
        .h_cnt         (cnt[AX_H]),
        .v_cnt         (cnt[AX_V]),
        .v_sync_end    (v_sync_end),
        .v_act_end     (v_act_end),
        .irq_clr       (irq_clr),
        .fetch_stb     (fetch_stb),
        .vevent_pulse  (vevent_pulse),
        .vevent_status (vevent_status)
    );

    // R8 / R9: an edge without a legal enable parks the raster at the origin, blanked
    assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
        !go |=> (h_count == '0 && v_count == '0 && !de && !fetch_stb));

    // R8: the first enabled edge after a stop restarts at the origin
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (go && !running) |=> (h_count == '0 && v_count == '0));

    // R3: while stopped each sync sits at the complement of its polarity
    assert_idle_sync_R3: assert property (@(posedge clk) disable iff (rst)
        !running |-> (hsync == !hs_pol && vsync == !vs_pol));

    // R4: data-enable only inside the visible pixel window
    assert_de_window_R4: assert property (@(posedge clk) disable iff (rst)
        de |-> (h_count >= h_act_start && h_count < h_act_end));

endmodule

// File: tb/edge_timing_gen_test.sv
module edge_timing_gen_test;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sync_en = 1'b0;
    logic         hs_pol = 1'b1;
    logic         vs_pol = 1'b0;
    logic [W-1:0] h_sync_end = 12'd4, h_act_start = 12'd8, h_act_end = 12'd24, h_total = 12'd28;
    logic [W-1:0] v_sync_end = 12'd2, v_act_start = 12'd4, v_act_end = 12'd20, v_total = 12'd22;
    logic         irq_clr = 1'b0;
    logic         hsync, vsync, de, fetch_stb, vevent_pulse, vevent_status;
    logic [W-1:0] h_count, v_count;

    edge_timing_gen uut (
        .clk(clk), .rst(rst), .sync_en(sync_en), .hs_pol(hs_pol), .vs_pol(vs_pol),
        .h_sync_end(h_sync_end), .h_act_start(h_act_start), .h_act_end(h_act_end), .h_total(h_total),
        .v_sync_end(v_sync_end), .v_act_start(v_act_start), .v_act_end(v_act_end), .v_total(v_total),
        .irq_clr(irq_clr), .hsync(hsync), .vsync(vsync), .de(de),
        .h_count(h_count), .v_count(v_count), .fetch_stb(fetch_stb),
        .vevent_pulse(vevent_pulse), .vevent_status(vevent_status)
    );

    always #4 clk = ~clk;   // 125 MHz

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int vpulses = 0;
    int fpulses = 0;
    int max_h = 0;

    typedef struct {
        logic         hs, vs, de, fs, vp, st;
        logic [W-1:0] h, v;
    } exp_t;

    exp_t exp_q[$];

    // Independent reference state
    bit       m_run = 0, m_stat = 0;
    int       m_h = 0, m_v = 0;

    function automatic bit axis_ok(int se, int as, int ae, int tot);
        return (se > 0) && (se <= as) && (ae - as >= 16) && (ae - as <= 2048) && (ae < tot);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
        end
    endtask

    // Driver side of the scoreboard: predict every cycle, push into the queue
    always @(posedge clk) begin
        exp_t e;
        bit ok, pulse_old;
        pulse_old = m_run && m_h == 0 && m_v == int'(v_act_end);
        ok = sync_en && axis_ok(h_sync_end, h_act_start, h_act_end, h_total)
                     && axis_ok(v_sync_end, v_act_start, v_act_end, v_total);
        if (rst) begin
            m_run = 0; m_h = 0; m_v = 0; m_stat = 0;
        end else begin
            if (pulse_old) m_stat = 1;
            else if (irq_clr) m_stat = 0;
            if (!ok) begin
                m_run = 0; m_h = 0; m_v = 0;
            end else if (!m_run) begin
                m_run = 1;
            end else if (m_h >= int'(h_total) - 1) begin
                m_h = 0;
                if (m_v >= int'(v_total) - 1) m_v = 0; else m_v++;
            end else begin
                m_h++;
            end
        end
        e.h  = W'(m_h);
        e.v  = W'(m_v);
        e.hs = (m_run && m_h < int'(h_sync_end)) ? hs_pol : !hs_pol;
        e.vs = (m_run && m_v < int'(v_sync_end)) ? vs_pol : !vs_pol;
        e.de = m_run && m_h >= int'(h_act_start) && m_h < int'(h_act_end)
                     && m_v >= int'(v_act_start) && m_v < int'(v_act_end);
        e.fs = m_run && m_h == 0 && m_v == int'(v_sync_end);
        e.vp = m_run && m_h == 0 && m_v == int'(v_act_end);
        e.st = m_stat;
        exp_q.push_back(e);
    end

    // Monitor side: pop and compare half a cycle later
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(h_count == e.h, "R2", "h_count", h_count, e.h);
            chk(v_count == e.v, "R2", "v_count", v_count, e.v);
            chk(hsync == e.hs, "R3", "hsync", hsync, e.hs);
            chk(vsync == e.vs, "R3", "vsync", vsync, e.vs);
            chk(de == e.de, "R4", "de", de, e.de);
            chk(vevent_pulse == e.vp, "R5", "vevent_pulse", vevent_pulse, e.vp);
            chk(fetch_stb == e.fs, "R6", "fetch_stb", fetch_stb, e.fs);
            chk(vevent_status == e.st, "R7", "vevent_status", vevent_status, e.st);
            if (vevent_pulse) vpulses++;
            if (fetch_stb) fpulses++;
            if (int'(h_count) > max_h) max_h = int'(h_count);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_h(int se, int as, int ae, int tot);
        h_sync_end = W'(se); h_act_start = W'(as); h_act_end = W'(ae); h_total = W'(tot);
    endtask

    task automatic expect_blank(string req, int n);
        for (int i = 0; i < n; i++) begin
            tick(1);
            chk(h_count == 0 && v_count == 0 && !de, req, "held blank counters", int'(h_count), 0);
            chk(hsync == !hs_pol && vsync == !vs_pol, req, "idle sync level", hsync, !hs_pol);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        tick(4);
        // R1: reset state
        chk(h_count == 0 && v_count == 0, "R1", "counters in reset", int'(h_count), 0);
        chk(!de && !fetch_stb && !vevent_pulse && !vevent_status, "R1", "flags in reset", de, 0);
        chk(hsync == 1'b0 && vsync == 1'b1, "R1", "sync idle in reset", {hsync, vsync}, 1);
        rst = 1'b0;
        expect_blank("R1", 5);

        // R8: start and first count
        sync_en = 1'b1;
        tick(6);
        chk(h_count == 5 && v_count == 0, "R8", "count after start", int'(h_count), 5);

        // R5 / R6: two whole frames give one pulse each per frame
        vpulses = 0; fpulses = 0;
        tick(2 * 28 * 22);
        chk(vpulses == 2, "R5", "interrupts in two frames", vpulses, 2);
        chk(fpulses == 2, "R6", "fetch strobes in two frames", fpulses, 2);

        // R7: sticky status and write-one clear
        chk(vevent_status == 1'b1, "R7", "status after pulses", vevent_status, 1);
        vpulses = 0;
        while (vpulses == 0) tick(1);
        tick(10);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
        tick(1);
        chk(vevent_status == 1'b0, "R7", "status after clear", vevent_status, 0);
        vpulses = 0;
        while (vpulses == 0) tick(1);
        tick(1);
        chk(vevent_status == 1'b1, "R7", "status set again", vevent_status, 1);
        // R7: clear held across a pulse leaves the status set
        irq_clr = 1'b1;
        vpulses = 0;
        while (vpulses == 0) tick(1);
        irq_clr = 1'b0;
        tick(1);
        chk(vevent_status == 1'b1, "R7", "pulse beats clear", vevent_status, 1);

        // R3: polarity flip while running
        hs_pol = 1'b0; vs_pol = 1'b1;
        tick(700);

        // R8: mid-frame stop, blank, restart from origin
        sync_en = 1'b0;
        expect_blank("R8", 20);
        hs_pol = 1'b1;
        expect_blank("R8", 3);
        sync_en = 1'b1;
        tick(1);
        chk(h_count == 0 && v_count == 0, "R8", "restart at origin", int'(h_count), 0);
        tick(300);

        // R9: illegal edge sets keep the raster parked
        sync_en = 1'b0; tick(1);
        set_h(4, 8, 23, 28);            // span 15
        sync_en = 1'b1;
        expect_blank("R9", 40);
        set_h(4, 8, 2057, 2060);        // span 2049
        expect_blank("R9", 40);
        set_h(4, 8, 24, 24);            // total equals act_end
        expect_blank("R9", 40);
        set_h(0, 8, 24, 28);            // zero-length sync
        expect_blank("R9", 40);
        set_h(4, 8, 24, 28);
        v_act_end = 12'd19;             // vertical span 15
        expect_blank("R9", 40);
        v_act_end = 12'd20;
        tick(1);
        chk(h_count == 0, "R9", "legal set runs again", int'(h_count), 0);
        tick(200);

        // R9 / R2: maximum span 2048 is accepted and the pixel count reaches it
        sync_en = 1'b0; tick(1);
        set_h(4, 8, 2056, 2060);
        sync_en = 1'b1;
        max_h = 0;
        tick(2100);
        chk(max_h == 2059, "R9", "wide line counted to total-1", max_h, 2059);
        chk(v_count == 1, "R2", "line advanced after wide wrap", int'(v_count), 1);

        finish_up();
    end

endmodule